// File: doc/BRIEF.md
# D-PHY Test-Port Configuration Writer

This block performs a single write into a configuration register inside a D-PHY. The PHY exposes a strobe-based test port: a clear line, a test clock, an enable line and an 8-bit bus that carries the register code and then the data. The block runs the whole handshake as eight timed phases. The register code is taken on a falling test clock while enable is high. The data byte is taken on the next rising test clock while enable is low.

A host starts a write with a one-cycle `start` pulse. It can supply the register code and data directly. It can instead supply a per-lane bit rate in Mbps, or ask for the built-in default rate. In that case a lookup turns the rate into the PHY's frequency-range selection code and writes it to the range register. A rate above the highest supported band raises `error` and no write takes place.

While a write runs, `busy` is high. `done` pulses when the write completes. Every phase lasts a programmable number of system clock cycles, so the test clock meets the PHY's minimum pulse width.

Top module: `phy_cfg_writer`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `tp_clr`, `tp_clk` and `tp_en` are 0 and `tp_bus` is 0. These test-port lines stay all-zero whenever no write is running.
- R2: A write begins with a clear phase and then a gap phase.
  - In the clear phase `tp_clr` is 1 and `tp_clk`, `tp_en` and `tp_bus` are 0.
  - In the gap phase all four test-port lines are 0.
- R3: The address part follows three phases:
  - `tp_clk` is raised while `tp_en`=0 and `tp_bus`=0.
  - `tp_en`=1 and the register code appear on `tp_bus` while `tp_clk` stays 1.
  - `tp_clk` falls while `tp_en` stays 1 and the code stays on the bus. A port receiver latches the code on this falling edge.
- R4: The data part follows three phases:
  - The data byte is placed on `tp_bus` with `tp_en`=0 and `tp_clk`=0.
  - `tp_clk` rises, still with `tp_en`=0. A receiver latches the data on this rising edge.
  - A final phase drives `tp_clk` to 0.
- R5: Each of the eight phases lasts H cycles, where H is `hold_cycles` sampled at the accepted start. A value of 0 counts as 1.
  - `busy` rises in the cycle after the start is accepted.
  - `busy` stays high for exactly 8*H cycles.
- R6: `done` is high for exactly one cycle, which is the first cycle with `busy` low after a write. In that cycle all test-port lines are 0.
- R7: A `start` while `busy` is high is ignored.
  - The running write keeps its code and data.
  - No second write follows.
- R8: In rate mode (`mode_rate`=1) the register code is 0x44. The data is the code of the first band whose upper limit is strictly greater than the rate. Bands are listed as limit:code, in ascending limit order:
  - 90:00, 100:20, 110:40, 125:02, 140:22, 150:42, 160:04, 180:24
  - 200:44, 210:06, 240:26, 250:46, 270:08, 300:28, 330:48, 360:2A
  - 400:4A, 450:0C, 500:2C, 550:0E, 600:2E, 650:10, 700:30, 750:12
  - 800:32, 850:14, 900:34, 950:54, 1000:74
- R9: In rate mode, a rate of 1000 or more gives the following:
  - `error` is high for exactly the one cycle after the start.
  - `busy` does not rise.
  - No test-port line moves.
- R10: In rate mode with `use_default_rate`=1, `rate_mbps` is ignored and 849 Mbps is used, which writes 0x14.
- R11: In direct mode (`mode_rate`=0), `reg_code` and `reg_data` are written as given and `error` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a write |
| mode_rate | input | 1 | 1: derive the write from a bit rate; 0: direct code and data |
| use_default_rate | input | 1 | In rate mode, use 849 Mbps instead of `rate_mbps` |
| rate_mbps | input | RATE_W | Requested per-lane bit rate in Mbps |
| reg_code | input | 8 | Register code for a direct write |
| reg_data | input | 8 | Data byte for a direct write |
| hold_cycles | input | HOLD_W | Cycles per phase (0 treated as 1) |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when a write completes |
| error | output | 1 | One-cycle pulse for an out-of-range rate |
| tp_clr | output | 1 | Test-port clear |
| tp_clk | output | 1 | Test-port strobe clock |
| tp_en | output | 1 | Test-port enable (high marks the address phase) |
| tp_bus | output | 8 | Shared address/data bus of the test port |

## Verification
The bench models a port receiver that latches on the test-clock edges. It sweeps every rate from 0 to 1010 Mbps, which covers each band's edge on both sides and the first out-of-range values. It also tries large rates and the default-rate request. These runs separate a correct threshold comparison from one that is off by one or uses a non-strict compare. Direct writes with distinct code and data bytes, at several hold lengths including zero, show whether code and data are swapped or latched on the wrong edge, and whether the phase timing is scaled correctly. One start pulse is placed in the middle of a running write. It shows whether a request is wrongly accepted while busy.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CLR,
    PH_GAP,
    PH_CKHI,
    PH_ADDR,
    PH_ALAT,
    PH_DATA,
    PH_DLAT,
    PH_TAIL
  } phase_e;

  localparam logic [7:0] RANGE_REG_CODE = 8'h44;
  localparam int         DEFAULT_RATE   = 849;
  localparam int         N_BANDS        = 29;
  localparam int         N_PHASES       = 8;

  function automatic int band_limit(input int idx);
    case (idx)
      0: band_limit = 90;    1: band_limit = 100;   2: band_limit = 110;
      3: band_limit = 125;   4: band_limit = 140;   5: band_limit = 150;
      6: band_limit = 160;   7: band_limit = 180;   8: band_limit = 200;
      9: band_limit = 210;   10: band_limit = 240;  11: band_limit = 250;
      12: band_limit = 270;  13: band_limit = 300;  14: band_limit = 330;
      15: band_limit = 360;  16: band_limit = 400;  17: band_limit = 450;
      18: band_limit = 500;  19: band_limit = 550;  20: band_limit = 600;
      21: band_limit = 650;  22: band_limit = 700;  23: band_limit = 750;
      24: band_limit = 800;  25: band_limit = 850;  26: band_limit = 900;
      27: band_limit = 950;  default: band_limit = 1000;
    endcase
  endfunction

  function automatic logic [7:0] band_code(input int idx);
    case (idx)
      0: band_code = 8'h00;  1: band_code = 8'h20;  2: band_code = 8'h40;
      3: band_code = 8'h02;  4: band_code = 8'h22;  5: band_code = 8'h42;
      6: band_code = 8'h04;  7: band_code = 8'h24;  8: band_code = 8'h44;
      9: band_code = 8'h06;  10: band_code = 8'h26; 11: band_code = 8'h46;
      12: band_code = 8'h08; 13: band_code = 8'h28; 14: band_code = 8'h48;
      15: band_code = 8'h2a; 16: band_code = 8'h4a; 17: band_code = 8'h0c;
      18: band_code = 8'h2c; 19: band_code = 8'h0e; 20: band_code = 8'h2e;
      21: band_code = 8'h10; 22: band_code = 8'h30; 23: band_code = 8'h12;
      24: band_code = 8'h32; 25: band_code = 8'h14; 26: band_code = 8'h34;
      27: band_code = 8'h54; default: band_code = 8'h74;
    endcase
  endfunction

endpackage

// File: rtl/freq_band_lookup.sv
module freq_band_lookup #(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate,
  output logic [7:0]        sel_code,
  output logic              out_of_range
);
  import phy_cfg_pkg::*;

  localparam int RATE_EXT_W = 32;

  logic [RATE_EXT_W-1:0] rate_ext;
  assign rate_ext = RATE_EXT_W'(rate);

  // Walk from the top band down so the lowest matching band wins.
  always_comb begin
    sel_code     = 8'h00;
    out_of_range = 1'b1;
    for (int i = N_BANDS - 1; i >= 0; i--) begin
      if (RATE_EXT_W'(band_limit(i)) > rate_ext) begin
        sel_code     = band_code(i);
        out_of_range = 1'b0;
      end
    end
  end

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] hold_eff,
  output logic              expire
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= hold_eff - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);

  // R5: a freshly loaded count never exceeds the hold it was given
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (cnt_q < $past(hold_eff)));

endmodule

// File: rtl/tport_sequencer.sv
module tport_sequencer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [7:0]        code_in,
  input  logic [7:0]        data_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              busy,
  output logic              done,
  output logic              tp_clr,
  output logic              tp_clk,
  output logic              tp_en,
  output logic [7:0]        tp_bus
);
  import phy_cfg_pkg::*;

  phase_e            ph_q;
  logic [7:0]        code_q, data_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_new;
  logic [HOLD_W-1:0] load_val;
  logic              expire;
  logic              step;
  logic              tload;

  assign hold_new = (hold_in == '0) ? HOLD_W'(1) : hold_in;
  assign step     = (ph_q != PH_IDLE) && expire;
  assign tload    = (launch && ph_q == PH_IDLE) || (step && ph_q != PH_TAIL);
  assign load_val = (ph_q == PH_IDLE) ? hold_new : hold_q;

  phase_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tload),
    .hold_eff (load_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      code_q <= '0;
      data_q <= '0;
      hold_q <= HOLD_W'(1);
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (launch) begin
          ph_q   <= PH_CLR;
          code_q <= code_in;
          data_q <= data_in;
          hold_q <= hold_new;
        end
      end else if (step) begin
        case (ph_q)
          PH_CLR:  ph_q <= PH_GAP;
          PH_GAP:  ph_q <= PH_CKHI;
          PH_CKHI: ph_q <= PH_ADDR;
          PH_ADDR: ph_q <= PH_ALAT;
          PH_ALAT: ph_q <= PH_DATA;
          PH_DATA: ph_q <= PH_DLAT;
          PH_DLAT: ph_q <= PH_TAIL;
          default: begin
            ph_q <= PH_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy = (ph_q != PH_IDLE);

  always_comb begin
    tp_clr = 1'b0;
    tp_clk = 1'b0;
    tp_en  = 1'b0;
    tp_bus = 8'h00;
    case (ph_q)
      PH_CLR:  tp_clr = 1'b1;
      PH_CKHI: tp_clk = 1'b1;
      PH_ADDR: begin tp_clk = 1'b1; tp_en = 1'b1; tp_bus = code_q; end
      PH_ALAT: begin tp_en = 1'b1; tp_bus = code_q; end
      PH_DATA: tp_bus = data_q;
      PH_DLAT: begin tp_clk = 1'b1; tp_bus = data_q; end
      PH_TAIL: tp_bus = data_q;
      default: ;
    endcase
  end

  // R2: clear is only ever driven with the other lines quiet
  a_r2_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tp_clr |-> (!tp_clk && !tp_en && tp_bus == 8'h00));
  // R3: enable rises only while the test clock is already high
  a_r3_en_under_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_en) |-> (tp_clk && $past(tp_clk)));
  // R3: the bus holds steady across the address-latching fall
  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tp_clk) && tp_en) |-> $stable(tp_bus));
  // R4: the bus holds steady across the data-latching rise
  a_r4_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tp_clk) && !tp_en && tp_bus != 8'h00) |-> $stable(tp_bus));
  // R6: done is a single-cycle pulse right after busy ends
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R7: operands do not change while a write runs
  a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(code_q) && $stable(data_q)));
  // R1: test-port lines idle whenever no write runs
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tp_clr && !tp_clk && !tp_en && tp_bus == 8'h00));

endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer #(
  parameter int RATE_W = 11,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_rate,
  input  logic              use_default_rate,
  input  logic [RATE_W-1:0] rate_mbps,
  input  logic [7:0]        reg_code,
  input  logic [7:0]        reg_data,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              tp_clr,
  output logic              tp_clk,
  output logic              tp_en,
  output logic [7:0]        tp_bus
);
  import phy_cfg_pkg::*;

  logic [RATE_W-1:0] rate_eff;
  logic [7:0]        sel_code;
  logic              oor;
  logic              accept;
  logic              reject;
  logic              launch;
  logic [7:0]        wr_code, wr_data;
  logic              error_q;

  assign rate_eff = use_default_rate ? RATE_W'(DEFAULT_RATE) : rate_mbps;

  freq_band_lookup #(.RATE_W(RATE_W)) u_lookup (
    .rate         (rate_eff),
    .sel_code     (sel_code),
    .out_of_range (oor)
  );

  assign accept  = start && !busy;
  assign reject  = accept && mode_rate && oor;
  assign launch  = accept && !reject;
  assign wr_code = mode_rate ? RANGE_REG_CODE : reg_code;
  assign wr_data = mode_rate ? sel_code : reg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) error_q <= 1'b0;
    else        error_q <= reject;
  end
  assign error = error_q;

  tport_sequencer #(.HOLD_W(HOLD_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .code_in (wr_code),
    .data_in (wr_data),
    .hold_in (hold_cycles),
    .busy    (busy),
    .done    (done),
    .tp_clr  (tp_clr),
    .tp_clk  (tp_clk),
    .tp_en   (tp_en),
    .tp_bus  (tp_bus)
  );

  // R9: an error never comes with a running write
  a_r9_error_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && !tp_clr));
  // R9: an error follows a rate-mode request
  a_r9_error_from_rate: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> ($past(start) && $past(mode_rate)));
  // R11: a direct request never yields an error
  a_r11_direct_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode_rate) |=> !error);

endmodule

// File: tb/phy_cfg_writer_tb.sv
module phy_cfg_writer_tb;
  localparam int RATE_W = 11;
  localparam int HOLD_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_rate = 1'b0, use_default_rate = 1'b0;
  logic [RATE_W-1:0] rate_mbps = '0;
  logic [7:0] reg_code = '0, reg_data = '0;
  logic [HOLD_W-1:0] hold_cycles = '0;
  logic busy, done, error, tp_clr, tp_clk, tp_en;
  logic [7:0] tp_bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  phy_cfg_writer #(.RATE_W(RATE_W), .HOLD_W(HOLD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rate(mode_rate),
    .use_default_rate(use_default_rate), .rate_mbps(rate_mbps),
    .reg_code(reg_code), .reg_data(reg_data), .hold_cycles(hold_cycles),
    .busy(busy), .done(done), .error(error), .tp_clr(tp_clr),
    .tp_clk(tp_clk), .tp_en(tp_en), .tp_bus(tp_bus)
  );

  // Port receiver model: code latched on a falling clock with enable high,
  // data on a rising clock with enable low; clear wipes both.
  logic [7:0] rx_addr = '0, rx_data = '0;
  logic prev_clk = 1'b0;
  int clr_n = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tp_clr) begin
      rx_addr <= '0;
      rx_data <= '0;
      clr_n   <= clr_n + 1;
    end else begin
      if (prev_clk && !tp_clk && tp_en)  rx_addr <= tp_bus;
      if (!prev_clk && tp_clk && !tp_en) rx_data <= tp_bus;
    end
    prev_clk <= tp_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_band(input int r);
    if (r < 90) return 8'h00;   if (r < 100) return 8'h20;
    if (r < 110) return 8'h40;  if (r < 125) return 8'h02;
    if (r < 140) return 8'h22;  if (r < 150) return 8'h42;
    if (r < 160) return 8'h04;  if (r < 180) return 8'h24;
    if (r < 200) return 8'h44;  if (r < 210) return 8'h06;
    if (r < 240) return 8'h26;  if (r < 250) return 8'h46;
    if (r < 270) return 8'h08;  if (r < 300) return 8'h28;
    if (r < 330) return 8'h48;  if (r < 360) return 8'h2a;
    if (r < 400) return 8'h4a;  if (r < 450) return 8'h0c;
    if (r < 500) return 8'h2c;  if (r < 550) return 8'h0e;
    if (r < 600) return 8'h2e;  if (r < 650) return 8'h10;
    if (r < 700) return 8'h30;  if (r < 750) return 8'h12;
    if (r < 800) return 8'h32;  if (r < 850) return 8'h14;
    if (r < 900) return 8'h34;  if (r < 950) return 8'h54;
    if (r < 1000) return 8'h74;
    return -1;
  endfunction

  // Runs one accepted write and checks timing and the received bytes.
  task automatic run_write(input int exp_code, input int exp_data, input int hold,
                           input bit inject, input string req);
    int n = 0;
    int h;
    int clr0;
    h = (hold == 0) ? 1 : hold;
    clr0 = clr_n;
    @(negedge clk);
    start = 1'b0;
    while (busy && n < 1000) begin
      n++;
      if (inject && n == 3) begin
        start = 1'b1; mode_rate = 1'b0; reg_code = 8'hAA; reg_data = 8'h55;
      end
      if (inject && n == 4) start = 1'b0;
      @(negedge clk);
    end
    check(n == 8 * h, "R5 busy length", n, 8 * h);
    check(done === 1'b1, "R6 done after busy", done, 1);
    check(!tp_clr && !tp_clk && !tp_en && tp_bus == 0, "R6 lines idle at done", tp_bus, 0);
    check(rx_addr == exp_code[7:0], {req, " code"}, rx_addr, exp_code);
    check(rx_data == exp_data[7:0], {req, " data"}, rx_data, exp_data);
    if (hold != 1) check(clr_n - clr0 == h, "R2 clear width", clr_n - clr0, h);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R6 done single / R7 no second write",
          {done, busy}, 0);
  endtask

  task automatic direct(input int code, input int data, input int hold, input bit inject);
    start = 1'b1; mode_rate = 1'b0; use_default_rate = 1'b0;
    reg_code = code[7:0]; reg_data = data[7:0]; hold_cycles = hold[HOLD_W-1:0];
    run_write(code, data, hold, inject, inject ? "R7 ignored start" : "R11 direct");
  endtask

  task automatic by_rate(input int r, input bit use_def);
    int eff;
    int e;
    eff = use_def ? 849 : r;
    e = exp_band(eff);
    start = 1'b1; mode_rate = 1'b1; use_default_rate = use_def;
    rate_mbps = r[RATE_W-1:0]; reg_code = 8'h99; reg_data = 8'h66; hold_cycles = 1;
    if (e < 0) begin
      @(negedge clk);
      start = 1'b0;
      check(error === 1'b1 && busy === 1'b0, "R9 error pulse", {error, busy}, 2);
      @(negedge clk);
      check(error === 1'b0 && busy === 1'b0 && !tp_clr && !tp_clk && tp_bus == 0,
            "R9 no write", {error, busy, tp_bus}, 0);
    end else begin
      run_write(8'h44, e, 1, 1'b0, use_def ? "R10 default rate" : "R8 band");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !tp_clr && !tp_clk && !tp_en && tp_bus == 0,
          "R1 reset state", {busy, done, error, tp_bus}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !tp_clr && tp_bus == 0, "R1 idle after reset", busy, 0);

    // R3 R4: direct writes with distinct bytes and several hold lengths
    direct(8'h44, 8'h14, 1, 1'b0);
    direct(8'hC3, 8'h3C, 3, 1'b0);
    direct(8'h01, 8'hFE, 0, 1'b0);
    direct(8'h80, 8'h7F, 15, 1'b0);
    direct(8'h5A, 8'hA5, 2, 1'b1);

    // R8 R9: sweep of rates across every band edge and past the top
    for (int r = 0; r <= 1010; r++) by_rate(r, 1'b0);
    by_rate(1500, 1'b0);
    by_rate(2047, 1'b0);
    // R10: default rate ignores the supplied rate
    by_rate(2047, 1'b1);
    by_rate(10, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule